// File: doc/BRIEF.md
# SPI Port with Sticky Collision and Overflow Flags

This block is a single-byte synchronous serial port. It runs either as the clock-driving end (master) or as the clock-following end (slave) of an SPI link. A processor reaches it through a small register interface with one select line. That interface exposes three registers: a data buffer, a control register and a status register. Internally, a shift register moves one byte per transfer, most significant bit first.

Two flags record misuse, and both stay set until software writes them back to zero. The collision flag marks a buffer write made while a byte is still in flight; that write is thrown away. The overflow flag marks a byte that finished arriving in slave mode while the previous received byte had not yet been read. In that case the new byte is dropped and the buffer keeps the old one. Overflow cannot happen in master mode, because there each transfer is started by software. When the port is disabled, every output enable is low, so the pins can serve as ordinary I/O.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register reads 0x00, the buffer and the status register read 0x00, `port_en`, `sck_oe` and `sdo_oe` are low, and `sck_o` is low.
- R2: Control bit 4 sets the idle level of the master clock: with bit 4 = 1, `sck_o` is high between transfers; with bit 4 = 0, it is low.
- R3: When the port is enabled and in master mode (control bit 2 = 0), a write to the buffer (address 0) made while idle starts an 8-bit, MSB-first transfer. Each bit lasts 4 clock cycles. SDI is sampled on the first SCK edge away from idle, and at the end of the transfer the received byte is placed in the buffer.
- R4: In master mode, a buffer write made during a transfer sets the collision flag (control bit 7) and is ignored. The byte in flight and the received result are unaffected.
- R5: In slave mode (control bit 2 = 1), a buffer write made after the first leading SCK edge of a byte and before that byte completes sets the collision flag and is ignored.
- R6: The collision and overflow flags (control bits 7 and 6) are never cleared by hardware. Only a control-register write that carries 0 in those bits clears them.
- R7: Status register (address 2) bit 0 is buffer-full: it sets when a received byte is stored and clears when the buffer is read. Bit 1 reads 1 while a transfer is in progress.
- R8: In slave mode, the port samples SDI on the leading edge of the external SCK and shifts on the trailing edge. It sends the byte last written to the buffer, MSB first. After 8 bits, the received byte goes to the buffer.
- R9: If a slave byte completes while buffer-full is set, the overflow flag (control bit 6) sets and the buffer keeps its previous byte.
- R10: The overflow flag is never set in master mode, even when received bytes are not read.
- R11: In slave mode with control bit 0 = 0, a high slave-select clears the bit count and turns `sdo_oe` low. The next byte after select returns is received whole.
- R12: With control bit 5 = 0 (disabled), `port_en`, `sck_oe` and `sdo_oe` are low, and a buffer write stores the byte without starting a transfer.
- R13: In slave mode with control bit 0 = 1, slave-select is ignored: bytes are received and `sdo_oe` stays high while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | 0 buffer, 1 control, 2 status |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after the access |
| sck_i | input | 1 | Serial clock from the link (slave) |
| sck_o | output | 1 | Serial clock driven (master) |
| sck_oe | output | 1 | Drive enable for the serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for serial data out |
| ss_n_i | input | 1 | Active-low slave select |
| port_en | output | 1 | Port owns its pins (control bit 5) |

## Verification
The hardest state to reach from the ports is a slave byte that is cut off partway through. This covers both a buffer write landing between the leading and trailing SCK edges of a bit and slave-select rising after only part of a byte has shifted in. The bench drives the external clock by hand, one edge at a time and several system cycles apart. That lets it place a buffer write inside the first bit, then raise select, then send a full byte and check that the byte arrives whole. Overflow is reached by sending two slave bytes back to back without reading the buffer in between.

// File: rtl/spi_pkg.sv
package spi_pkg;

  localparam int CTL_W = 8;

  typedef struct packed {
    logic       wcol;   // write collision, sticky
    logic       ov;     // receive overflow, sticky
    logic       en;     // port enable
    logic       ckp;    // clock idle level
    logic [3:0] mode;   // bit 2: slave, bit 0: ignore select (slave)
  } ctl_t;

  localparam logic [1:0] A_BUF  = 2'd0;
  localparam logic [1:0] A_CTL  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  function automatic logic mode_is_slave(input logic [3:0] m);
    return m[2];
  endfunction

  function automatic logic mode_ss_ignored(input logic [3:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= RST_VAL;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/spi_master_eng.sv
module spi_master_eng #(
  parameter int DATA_W = 8,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ckp,
  input  logic              start,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              sdo
);

  localparam int PH_W  = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int HALF  = DIV / 2;
  localparam logic [PH_W-1:0]  PH_LEAD  = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  bitc;
  logic [DATA_W-1:0] sr;
  logic              rx_bit;
  logic              sck_r;
  logic [DATA_W-1:0] shifted;

  assign shifted = {sr[DATA_W-2:0], rx_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ph     <= '0;
      bitc   <= '0;
      sr     <= '0;
      rx_bit <= 1'b0;
      sck_r  <= ckp;
    end else if (start) begin
      busy   <= 1'b1;
      ph     <= '0;
      bitc   <= '0;
      sr     <= load_data;
      sck_r  <= ckp;
    end else if (busy) begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      if (ph == PH_LEAD) begin
        rx_bit <= sdi;
        sck_r  <= ~ckp;
      end
      if (ph == PH_LAST) begin
        sr    <= shifted;
        sck_r <= ckp;
        bitc  <= (bitc == BIT_LAST) ? '0 : bitc + 1'b1;
        if (bitc == BIT_LAST) busy <= 1'b0;
      end
    end else begin
      sck_r <= ckp;
    end
  end

  assign done    = busy && (ph == PH_LAST) && (bitc == BIT_LAST);
  assign rx_data = shifted;
  assign sck     = sck_r;
  assign sdo     = sr[DATA_W-1];

endmodule

// File: rtl/spi_slave_eng.sv
module spi_slave_eng #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ckp,
  input  logic              ss_ign,
  input  logic              sck_s,
  input  logic              ss_s,
  input  logic              sdi_s,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              act,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sdo
);

  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [BIT_W-1:0]  bitc;
  logic [DATA_W-1:0] sr;
  logic              rx_bit;
  logic              prev;
  logic              edge_seen, lead, trail;
  logic [DATA_W-1:0] shifted;

  assign act       = ss_ign || !ss_s;
  assign edge_seen = act && (sck_s != prev);
  assign lead      = edge_seen && (sck_s != ckp);
  assign trail     = edge_seen && (sck_s == ckp) && busy;
  assign shifted   = {sr[DATA_W-2:0], rx_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      bitc   <= '0;
      sr     <= '0;
      rx_bit <= 1'b0;
      prev   <= ckp;
    end else begin
      prev <= sck_s;
      if (!act) begin
        busy <= 1'b0;
        bitc <= '0;
      end else if (lead) begin
        rx_bit <= sdi_s;
        busy   <= 1'b1;
      end else if (trail) begin
        sr   <= shifted;
        bitc <= (bitc == BIT_LAST) ? '0 : bitc + 1'b1;
        if (bitc == BIT_LAST) busy <= 1'b0;
      end
      if (load) sr <= load_data;
    end
  end

  assign done    = trail && (bitc == BIT_LAST);
  assign rx_data = shifted;
  assign sdo     = sr[DATA_W-1];

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i,
  output logic              port_en
);

  ctl_t              ctl;
  logic [CTL_W-1:0]  ctl_bits;
  logic [DATA_W-1:0] buf_q;
  logic              bf;
  logic              wr_buf, wr_ctl, rd_buf, rd_any;
  logic              slave, eng_busy, collide, accept, eng_done, bf_eff, ov_hit;
  logic [DATA_W-1:0] eng_rx;
  logic [2:0]        pins_s;
  logic              m_rst, s_rst;
  logic              m_busy, m_done, m_sck, m_sdo;
  logic              s_busy, s_act, s_done, s_sdo;
  logic [DATA_W-1:0] m_rx, s_rx;

  assign ctl_bits = ctl;
  assign slave    = mode_is_slave(ctl.mode);
  assign wr_buf   = cpu_sel && cpu_wr && (cpu_addr == A_BUF);
  assign wr_ctl   = cpu_sel && cpu_wr && (cpu_addr == A_CTL);
  assign rd_any   = cpu_sel && !cpu_wr;
  assign rd_buf   = rd_any && (cpu_addr == A_BUF);
  assign eng_busy = slave ? s_busy : m_busy;
  assign collide  = wr_buf && ctl.en && eng_busy;
  assign accept   = wr_buf && !collide;
  assign eng_done = slave ? s_done : m_done;
  assign eng_rx   = slave ? s_rx : m_rx;
  assign bf_eff   = bf && !rd_buf;
  assign ov_hit   = eng_done && slave && bf_eff;
  assign m_rst    = rst || !ctl.en || slave;
  assign s_rst    = rst || !ctl.en || !slave;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_i, ss_n_i, sdi_i}),
    .q   (pins_s)
  );

  spi_master_eng #(.DATA_W(DATA_W), .DIV(DIV)) u_mst (
    .clk       (clk),
    .rst       (m_rst),
    .ckp       (ctl.ckp),
    .start     (accept && ctl.en && !slave),
    .load_data (cpu_wdata),
    .sdi       (sdi_i),
    .busy      (m_busy),
    .done      (m_done),
    .rx_data   (m_rx),
    .sck       (m_sck),
    .sdo       (m_sdo)
  );

  spi_slave_eng #(.DATA_W(DATA_W)) u_slv (
    .clk       (clk),
    .rst       (s_rst),
    .ckp       (ctl.ckp),
    .ss_ign    (mode_ss_ignored(ctl.mode)),
    .sck_s     (pins_s[2]),
    .ss_s      (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .load      (accept && ctl.en && slave),
    .load_data (cpu_wdata),
    .busy      (s_busy),
    .act       (s_act),
    .done      (s_done),
    .rx_data   (s_rx),
    .sdo       (s_sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      buf_q <= '0;
      bf    <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= ctl_t'(cpu_wdata[CTL_W-1:0]);
      if (collide) ctl.wcol <= 1'b1;
      if (ov_hit)  ctl.ov   <= 1'b1;
      if (rd_buf) bf <= 1'b0;
      if (accept) buf_q <= cpu_wdata;
      if (eng_done && !ov_hit) begin
        buf_q <= eng_rx;
        bf    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (rd_any) begin
      case (cpu_addr)
        A_BUF:   cpu_rdata <= buf_q;
        A_CTL:   cpu_rdata <= DATA_W'(ctl_bits);
        A_STAT:  cpu_rdata <= DATA_W'({eng_busy, bf});
        default: cpu_rdata <= '0;
      endcase
    end
  end

  assign port_en = ctl.en;
  assign sck_o   = m_sck;
  assign sck_oe  = ctl.en && !slave;
  assign sdo_o   = slave ? s_sdo : m_sdo;
  assign sdo_oe  = ctl.en && (!slave || s_act);

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              port_en,
  input logic              sck_oe,
  input logic              sdo_oe,
  input logic              wr_buf,
  input logic              wr_ctl,
  input logic              rd_buf,
  input logic              eng_busy,
  input logic              eng_done,
  input logic              slave,
  input logic              wcol,
  input logic              ov,
  input logic              bf,
  input logic [DATA_W-1:0] buf_q
);

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !port_en |-> (!sck_oe && !sdo_oe)); // R12

  AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_buf && port_en && eng_busy) |=> wcol); // R4

  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wcol && !wr_ctl) |=> wcol); // R6

  AST_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ov && !wr_ctl) |=> ov); // R6

  AST_NO_OV_MASTER: assert property (@(posedge clk) disable iff (rst)
    (!slave && !ov && !wr_ctl) |=> !ov); // R10

  AST_OV_KEEPS_BUFFER: assert property (@(posedge clk) disable iff (rst)
    (!ov && !wr_ctl && eng_done && slave && bf && !rd_buf) |=> (ov && $stable(buf_q))); // R9

  AST_BF_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_buf && !eng_done) |=> !bf); // R7

endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .port_en  (port_en),
  .sck_oe   (sck_oe),
  .sdo_oe   (sdo_oe),
  .wr_buf   (wr_buf),
  .wr_ctl   (wr_ctl),
  .rd_buf   (rd_buf),
  .eng_busy (eng_busy),
  .eng_done (eng_done),
  .slave    (slave),
  .wcol     (ctl.wcol),
  .ov       (ctl.ov),
  .bf       (bf),
  .buf_q    (buf_q)
);

// File: tb/test_spi_port.sv
module test_spi_port;

  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       sck_drv = 1'b0, ss_drv = 1'b1, sdi_drv = 1'b0, loop = 1'b0;
  logic       sck_o, sck_oe, sdo_o, sdo_oe, port_en, sdi_i;
  logic       ckp_tb = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  assign sdi_i = loop ? sdo_o : sdi_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port i_spi_port (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sck_i(sck_drv), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .ss_n_i(ss_drv),
    .port_en(port_en)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] q_ctl, q_buf, q_rd;
  logic       q_bf;
  logic       mq_busy, mq_rx, mq_sck;
  int         mq_ph, mq_bit;
  logic [7:0] mq_sr;
  logic       sq_busy, sq_rx, sq_prev;
  int         sq_bit;
  logic [7:0] sq_sr;
  logic       hist_sck[2], hist_ss[2], hist_sdi[2];
  logic       wb, wc, rb, rdq, slv, en, ckp, bsy, coll, acc, mdone, sdone, bfe, sdi_now;
  logic       act, edg, lead, trail, sck_s;
  logic [7:0] rxv;

  always @(posedge clk) begin
    if (rst) begin
      q_ctl = 0; q_buf = 0; q_rd = 0; q_bf = 0;
      mq_busy = 0; mq_rx = 0; mq_sck = 0; mq_ph = 0; mq_bit = 0; mq_sr = 0;
      sq_busy = 0; sq_rx = 0; sq_prev = 0; sq_bit = 0; sq_sr = 0;
      hist_sck = '{0, 0}; hist_ss = '{1, 1}; hist_sdi = '{0, 0};
    end else begin
      wb  = cpu_sel && cpu_wr && cpu_addr == 0;
      wc  = cpu_sel && cpu_wr && cpu_addr == 1;
      rdq = cpu_sel && !cpu_wr;
      rb  = rdq && cpu_addr == 0;
      slv = q_ctl[2]; en = q_ctl[5]; ckp = q_ctl[4];
      bsy = slv ? sq_busy : mq_busy;
      coll = wb && en && bsy;
      acc  = wb && !coll;
      sdi_now = loop ? (slv ? sq_sr[7] : mq_sr[7]) : sdi_drv;
      mdone = 0; sdone = 0; rxv = 0;
      if (rdq) case (cpu_addr)
        0: q_rd = q_buf;
        1: q_rd = q_ctl;
        2: q_rd = {6'd0, bsy, q_bf};
        default: q_rd = 0;
      endcase
      // master
      if (!en || slv) begin
        mq_busy = 0; mq_ph = 0; mq_bit = 0; mq_sr = 0; mq_rx = 0; mq_sck = ckp;
      end else if (acc) begin
        mq_busy = 1; mq_ph = 0; mq_bit = 0; mq_sr = cpu_wdata; mq_sck = ckp;
      end else if (mq_busy) begin
        if (mq_ph == 1) begin mq_rx = sdi_now; mq_sck = !ckp; end
        if (mq_ph == 3) begin
          rxv = {mq_sr[6:0], mq_rx}; mq_sr = rxv; mq_sck = ckp;
          if (mq_bit == 7) begin mq_bit = 0; mq_busy = 0; mdone = 1; end
          else mq_bit++;
        end
        mq_ph = (mq_ph + 1) % 4;
      end else mq_sck = ckp;
      // slave
      if (!en || !slv) begin
        sq_busy = 0; sq_bit = 0; sq_sr = 0; sq_rx = 0; sq_prev = ckp;
      end else begin
        sck_s = hist_sck[1];
        act  = q_ctl[0] || !hist_ss[1];
        edg  = act && sck_s != sq_prev;
        lead = edg && sck_s != ckp;
        trail = edg && sck_s == ckp && sq_busy;
        sq_prev = sck_s;
        if (!act) begin sq_busy = 0; sq_bit = 0; end
        else if (lead) begin sq_rx = hist_sdi[1]; sq_busy = 1; end
        else if (trail) begin
          rxv = {sq_sr[6:0], sq_rx}; sq_sr = rxv;
          if (sq_bit == 7) begin sq_bit = 0; sq_busy = 0; sdone = 1; end
          else sq_bit++;
        end
        if (acc) sq_sr = cpu_wdata;
      end
      // buffer and flags
      bfe = q_bf && !rb;
      if (rb) q_bf = 0;
      if (acc) q_buf = cpu_wdata;
      if (wc) q_ctl = cpu_wdata;
      if (coll) q_ctl[7] = 1;
      if ((mdone || sdone) && slv && bfe) q_ctl[6] = 1;
      else if (mdone || sdone) begin q_buf = rxv; q_bf = 1; end
      hist_sck[1] = hist_sck[0]; hist_sck[0] = sck_drv;
      hist_ss[1]  = hist_ss[0];  hist_ss[0]  = ss_drv;
      hist_sdi[1] = hist_sdi[0]; hist_sdi[0] = sdi_i;
    end
  end

  task automatic cmp(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // compare model and design on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cmp("R2/R3 sck_o", {7'd0, sck_o}, {7'd0, mq_sck});
      cmp("R8 sdo_o", {7'd0, sdo_o}, {7'd0, q_ctl[2] ? sq_sr[7] : mq_sr[7]});
      cmp("R12 sck_oe", {7'd0, sck_oe}, {7'd0, q_ctl[5] && !q_ctl[2]});
      cmp("R11 sdo_oe", {7'd0, sdo_oe},
          {7'd0, q_ctl[5] && (!q_ctl[2] || q_ctl[0] || !hist_ss[1])});
      cmp("R12 port_en", {7'd0, port_en}, {7'd0, q_ctl[5]});
      cmp("R7 cpu_rdata", cpu_rdata, q_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
    @(negedge clk);
    v = cpu_rdata; cpu_sel = 0;
  endtask

  task automatic sxfer(input logic [7:0] tx, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sdi_drv = tx[i];
      tick(H);
      got[i] = sdo_o;
      sck_drv = ~ckp_tb;
      tick(H);
      sck_drv = ckp_tb;
    end
    tick(H);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, got;
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    cmp("R1 port_en", {7'd0, port_en}, 8'd0);
    cmp("R1 sck_oe", {7'd0, sck_oe}, 8'd0);
    cmp("R1 sdo_oe", {7'd0, sdo_oe}, 8'd0);
    cmp("R1 sck_o", {7'd0, sck_o}, 8'd0);
    rd(1, v); cmp("R1 control", v, 8'h00);
    rd(2, v); cmp("R1 status", v, 8'h00);
    rd(0, v); cmp("R1 buffer", v, 8'h00);

    // master, loopback
    loop = 1;
    wr(1, 8'h20);
    wr(0, 8'hA5); tick(40);
    wr(0, 8'h3C); tick(40);
    rd(1, v); cmp("R10 no overflow in master", v, 8'h20);
    rd(2, v); cmp("R7 buffer-full set", v, 8'h01);
    rd(0, v); cmp("R3 master receive", v, 8'h3C);
    rd(2, v); cmp("R7 buffer-full cleared", v, 8'h00);

    // R4 write during master transfer
    wr(0, 8'h5A); tick(5);
    rd(2, v); cmp("R7 busy bit", v, 8'h02);
    wr(0, 8'hFF); tick(40);
    rd(1, v); cmp("R4 collision flag", v, 8'hA0);
    rd(2, v); cmp("R4 no second transfer", v, 8'h01);
    rd(0, v); cmp("R4 byte in flight kept", v, 8'h5A);
    tick(20);
    rd(1, v); cmp("R6 collision sticky", v, 8'hA0);
    wr(1, 8'h20);
    rd(1, v); cmp("R6 collision cleared", v, 8'h20);

    // R2 idle-high clock
    wr(1, 8'h30); tick(2);
    cmp("R2 idle high", {7'd0, sck_o}, 8'd1);
    wr(0, 8'hC3); tick(40);
    cmp("R2 idle high after transfer", {7'd0, sck_o}, 8'd1);
    rd(0, v); cmp("R3 receive with idle-high clock", v, 8'hC3);

    // R12 disabled
    wr(1, 8'h00); tick(2);
    cmp("R12 port_en low", {7'd0, port_en}, 8'd0);
    wr(0, 8'h77);
    rd(2, v); cmp("R12 no transfer", v, 8'h00);
    tick(10);
    rd(0, v); cmp("R12 write stored", v, 8'h77);
    loop = 0;

    // slave, select used
    ckp_tb = 0; sck_drv = 0; ss_drv = 1;
    wr(1, 8'h24); tick(3);
    ss_drv = 0; tick(3);
    wr(0, 8'h96);
    sxfer(8'h3C, got);
    cmp("R8 slave transmit", got, 8'h96);
    rd(2, v); cmp("R7 slave buffer-full", v, 8'h01);
    rd(0, v); cmp("R8 slave receive", v, 8'h3C);

    // R9 overflow
    sxfer(8'h11, got);
    sxfer(8'h55, got);
    rd(1, v); cmp("R9 overflow flag", v, 8'h64);
    rd(0, v); cmp("R9 buffer keeps old byte", v, 8'h11);
    tick(20);
    rd(1, v); cmp("R6 overflow sticky", v, 8'h64);
    wr(1, 8'h24);
    rd(1, v); cmp("R6 overflow cleared", v, 8'h24);

    // R5 collision mid-byte, R11 select abort
    sdi_drv = 1; tick(H);
    sck_drv = 1; tick(H);
    wr(0, 8'h42);
    sck_drv = 0; tick(H);
    rd(1, v); cmp("R5 slave collision", v, 8'hA4);
    ss_drv = 1; tick(H);
    cmp("R11 sdo released", {7'd0, sdo_oe}, 8'd0);
    ss_drv = 0; tick(H);
    sxfer(8'h81, got);
    rd(0, v); cmp("R11 whole byte after abort", v, 8'h81);
    wr(1, 8'h24);

    // R13 select ignored
    wr(1, 8'h25);
    ss_drv = 1; tick(4);
    cmp("R13 sdo driven with select high", {7'd0, sdo_oe}, 8'd1);
    sxfer(8'hE7, got);
    rd(0, v); cmp("R13 receive with select high", v, 8'hE7);

    tick(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule